// File: doc/BRIEF.md
# Elastic-Store Line Clock Smoother

This block removes jitter from a recovered E1-rate bit stream. Each bit arrives with its own jittery line clock. The block samples that clock into a single system-clock domain and writes every bit into a circular elastic buffer. A second pointer reads the bits back out on a clean output clock, and that clock is made by dividing the system clock.

The system clock runs at twice the nominal reference rate. A nominal output bit therefore lasts 8 system-clock periods, which is a divide-by-4 of the reference. The block watches the distance between the write and read pointers. When the input runs ahead, the fill grows too large and the next output bit is shortened to 7 periods (divide-by-3.5). When the input falls behind, the fill drops too low and the next bit is stretched to 9 periods (divide-by-4.5). Each of these corrections raises a sticky trip flag.

The buffer depth is either 32 bits, for low delay, or 128 bits, for large wander. A bypass input removes the buffer from the path entirely. A path-select bit is passed through to an external mux. The line-side pins are a bare clock and data pair with no handshake. Nothing can push back on the line, so the block itself absorbs the rate difference and does not back-pressure the source.

Top module: `jitter_smoother`

## Requirements
- R1: With `deep_sel`=1 the buffer holds 128 bits; with `deep_sel`=0 it holds 32. After reset, with input and output at equal rates, output bit k equals input bit k−D/2, and the first D/2 output bits are 0 (D is the depth).
- R2: While the fill stays inside the window, each output clock period is exactly 8 system clocks.
- R3: When the fill seen at the start of an output bit is above D/2 + L/2, that bit lasts 7 system clocks. L is 120 at depth 128 and 28 at depth 32, so the thresholds are 124 and 30.
- R4: When the fill seen at the start of an output bit is below D/2 − L/2, that bit lasts 9 system clocks. The thresholds are 4 at depth 128 and 2 at depth 32.
- R5: `trip_flag` goes to 1 whenever a 7- or 9-period bit is chosen. It stays at 1 until a one-cycle `trip_clr` pulse clears it. If both happen in the same cycle, the set wins.
- R6: With `bypass`=1, `smooth_clk_out` equals `line_clk_in` and `smooth_dat_out` equals `line_dat_in` combinationally.
- R7: `path_sel_out` always equals `path_sel_in` and has no effect on data or timing.
- R8: Reset drives the output clock, output data and `trip_flag` to 0. Reset, or any change of `deep_sel`, sets the fill to D/2 and restarts the divider at 8 periods. A change of `deep_sel` leaves `trip_flag` unchanged.
- R9: `smooth_dat_out` changes only in the cycle in which `smooth_clk_out` rises.
- R10: `line_clk_in` passes through a two-flop synchronizer. Each detected rising edge writes exactly one bit, the value of `line_dat_in` at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, twice the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| deep_sel | input | 1 | 1 = 128-bit buffer, 0 = 32-bit buffer |
| bypass | input | 1 | 1 = pass line clock and data straight through |
| path_sel_in | input | 1 | Receive/transmit placement control |
| trip_clr | input | 1 | One-cycle pulse that clears the trip flag |
| line_clk_in | input | 1 | Jittery recovered line clock |
| line_dat_in | input | 1 | Line data, stable at the line clock rising edge |
| smooth_clk_out | output | 1 | Smoothed output clock |
| smooth_dat_out | output | 1 | Output data, updated on the output clock rise |
| trip_flag | output | 1 | Sticky flag set by any 3.5 or 4.5 division |
| path_sel_out | output | 1 | Mux select for the external path switch |

## Verification
The bench feeds the line faster and slower than the output at both depths, and measures the shortest and longest output periods it sees. A threshold that is off by one, or a swapped speed-up and slow-down, shows up as a missing 7 or 9 or as a stray one. At matched rates it compares the output stream against the input delayed by D/2. A wrong centring or a dropped synchronized edge shifts or corrupts that stream. It then switches depth after a trip. That catches a flag that is not sticky, a clear that does not work, or a divider that is not restarted at 8 and so produces a short first period.

// File: rtl/ja_pkg.sv
package ja_pkg;

  // Output bit lengths, in system-clock periods.
  localparam int unsigned SYS_PER_NOM  = 8;
  localparam int unsigned SYS_PER_FAST = SYS_PER_NOM - 1;
  localparam int unsigned SYS_PER_SLOW = SYS_PER_NOM + 1;

  typedef enum logic [1:0] {
    RATE_NOM  = 2'd0,
    RATE_FAST = 2'd1,
    RATE_SLOW = 2'd2
  } rate_e;

  function automatic int unsigned rate_len(input rate_e r);
    case (r)
      RATE_FAST: return SYS_PER_FAST;
      RATE_SLOW: return SYS_PER_SLOW;
      default:   return SYS_PER_NOM;
    endcase
  endfunction

endpackage

// File: rtl/ja_edge_sync.sv
module ja_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_clk,
  input  logic async_dat,
  output logic rise,
  output logic dat_sync
);

  logic [STAGES-1:0] clk_pipe;
  logic [STAGES-1:0] dat_pipe;
  logic              clk_hist;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_pipe <= '0;
      dat_pipe <= '0;
      clk_hist <= 1'b0;
    end else begin
      clk_pipe <= {clk_pipe[STAGES-2:0], async_clk};
      dat_pipe <= {dat_pipe[STAGES-2:0], async_dat};
      clk_hist <= clk_pipe[STAGES-1];
    end
  end

  assign rise     = clk_pipe[STAGES-1] & ~clk_hist;
  assign dat_sync = dat_pipe[STAGES-1];

  // R10: a detected edge is never followed at once by another one
  a_r10_single_rise: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/ja_elastic_buf.sv
module ja_elastic_buf #(
  parameter  int DEPTH_MAX = 128,
  parameter  int DEPTH_MIN = 32,
  localparam int PW        = $clog2(DEPTH_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deep_sel,
  input  logic          reinit,
  input  logic          wr_en,
  input  logic          wr_dat,
  input  logic          rd_en,
  output logic          rd_dat,
  output logic [PW-1:0] fill
);

  localparam logic [PW-1:0] MASK_MAX = PW'(DEPTH_MAX - 1);
  localparam logic [PW-1:0] MASK_MIN = PW'(DEPTH_MIN - 1);
  localparam logic [PW-1:0] MID_MAX  = PW'(DEPTH_MAX / 2);
  localparam logic [PW-1:0] MID_MIN  = PW'(DEPTH_MIN / 2);

  logic [DEPTH_MAX-1:0] store_q;
  logic [PW-1:0]        wptr_q, rptr_q;
  logic [PW-1:0]        mask, mid;

  assign mask = deep_sel ? MASK_MAX : MASK_MIN;
  assign mid  = deep_sel ? MID_MAX  : MID_MIN;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      store_q <= '0;
      wptr_q  <= MID_MIN;
      rptr_q  <= '0;
    end else if (reinit) begin
      wptr_q  <= mid;
      rptr_q  <= '0;
    end else begin
      if (wr_en) begin
        store_q[wptr_q] <= wr_dat;
        wptr_q          <= (wptr_q + 1'b1) & mask;
      end
      if (rd_en) begin
        rptr_q <= (rptr_q + 1'b1) & mask;
      end
    end
  end

  assign rd_dat = store_q[rptr_q];
  assign fill   = (wptr_q - rptr_q) & mask;

  // R1: pointers stay inside the selected depth
  a_r1_ptr_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    !reinit |-> (wptr_q <= mask) && (rptr_q <= mask));

  // R8: after a reinit the buffer sits at its centre
  a_r8_recentre: assert property (@(posedge clk) disable iff (!rst_n)
    reinit |=> (reinit || fill == mid));

endmodule

// File: rtl/ja_rate_div.sv
module ja_rate_div
  import ja_pkg::*;
#(
  parameter  int DEPTH_MAX = 128,
  parameter  int DEPTH_MIN = 32,
  parameter  int LIMIT_MAX = 120,
  parameter  int LIMIT_MIN = 28,
  localparam int PW        = $clog2(DEPTH_MAX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          deep_sel,
  input  logic          reinit,
  input  logic [PW-1:0] fill,
  input  logic          trip_clr,
  output logic          bit_start,
  output logic          clk_gen,
  output logic          trip
);

  localparam int CW = $clog2(SYS_PER_SLOW + 1);
  localparam int HI_LEN = SYS_PER_NOM / 2;
  localparam logic [PW-1:0] HI_THR_MAX = PW'(DEPTH_MAX / 2 + LIMIT_MAX / 2);
  localparam logic [PW-1:0] LO_THR_MAX = PW'(DEPTH_MAX / 2 - LIMIT_MAX / 2);
  localparam logic [PW-1:0] HI_THR_MIN = PW'(DEPTH_MIN / 2 + LIMIT_MIN / 2);
  localparam logic [PW-1:0] LO_THR_MIN = PW'(DEPTH_MIN / 2 - LIMIT_MIN / 2);

  logic [CW-1:0] cnt_q, cnt_nxt, len_q;
  logic          wrap;
  logic [PW-1:0] hi_thr, lo_thr;
  rate_e         rate_nxt;

  assign hi_thr = deep_sel ? HI_THR_MAX : HI_THR_MIN;
  assign lo_thr = deep_sel ? LO_THR_MAX : LO_THR_MIN;

  always_comb begin
    if (fill > hi_thr)      rate_nxt = RATE_FAST;
    else if (fill < lo_thr) rate_nxt = RATE_SLOW;
    else                    rate_nxt = RATE_NOM;
  end

  assign wrap      = (cnt_q == len_q - 1'b1);
  assign cnt_nxt   = wrap ? '0 : cnt_q + 1'b1;
  assign bit_start = wrap && !reinit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= CW'(SYS_PER_NOM - 1);
      len_q   <= CW'(SYS_PER_NOM);
      clk_gen <= 1'b0;
    end else if (reinit) begin
      cnt_q   <= CW'(SYS_PER_NOM - 1);
      len_q   <= CW'(SYS_PER_NOM);
      clk_gen <= 1'b0;
    end else begin
      cnt_q   <= cnt_nxt;
      clk_gen <= (cnt_nxt < CW'(HI_LEN));
      if (wrap) len_q <= CW'(rate_len(rate_nxt));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 trip <= 1'b0;
    else if (bit_start && rate_nxt != RATE_NOM) trip <= 1'b1;
    else if (trip_clr)                          trip <= 1'b0;
  end

  // R5: the flag holds until cleared
  a_r5_trip_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (trip && !trip_clr) |=> trip);

  // R2: only the three legal bit lengths occur
  a_r2_len_legal: assert property (@(posedge clk) disable iff (!rst_n)
    len_q == CW'(SYS_PER_NOM) || len_q == CW'(SYS_PER_FAST) ||
    len_q == CW'(SYS_PER_SLOW));

  // R3: a shortened bit sets the flag
  a_r3_fast_trips: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q == CW'(SYS_PER_FAST)) |-> trip || $past(trip_clr));

endmodule

// File: rtl/jitter_smoother.sv
module jitter_smoother #(
  parameter int DEPTH_MAX = 128,
  parameter int DEPTH_MIN = 32,
  parameter int LIMIT_MAX = 120,
  parameter int LIMIT_MIN = 28,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic deep_sel,
  input  logic bypass,
  input  logic path_sel_in,
  input  logic trip_clr,
  input  logic line_clk_in,
  input  logic line_dat_in,
  output logic smooth_clk_out,
  output logic smooth_dat_out,
  output logic trip_flag,
  output logic path_sel_out
);

  localparam int PW = $clog2(DEPTH_MAX);

  logic          depth_q, reinit;
  logic          wr_en, wr_dat, rd_en, rd_dat, clk_gen, dat_q;
  logic [PW-1:0] fill;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) depth_q <= 1'b0;
    else        depth_q <= deep_sel;
  end
  assign reinit = (deep_sel != depth_q);

  ja_edge_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .async_clk(line_clk_in), .async_dat(line_dat_in),
    .rise(wr_en), .dat_sync(wr_dat)
  );

  ja_elastic_buf #(.DEPTH_MAX(DEPTH_MAX), .DEPTH_MIN(DEPTH_MIN)) buf_i (
    .clk(clk), .rst_n(rst_n), .deep_sel(deep_sel), .reinit(reinit),
    .wr_en(wr_en), .wr_dat(wr_dat), .rd_en(rd_en), .rd_dat(rd_dat), .fill(fill)
  );

  ja_rate_div #(.DEPTH_MAX(DEPTH_MAX), .DEPTH_MIN(DEPTH_MIN),
                .LIMIT_MAX(LIMIT_MAX), .LIMIT_MIN(LIMIT_MIN)) div_i (
    .clk(clk), .rst_n(rst_n), .deep_sel(deep_sel), .reinit(reinit), .fill(fill),
    .trip_clr(trip_clr), .bit_start(rd_en), .clk_gen(clk_gen), .trip(trip_flag)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     dat_q <= 1'b0;
    else if (rd_en) dat_q <= rd_dat;
  end

  assign smooth_clk_out = bypass ? line_clk_in : clk_gen;
  assign smooth_dat_out = bypass ? line_dat_in : dat_q;
  assign path_sel_out   = path_sel_in;

  // R9: data moves only with the generated clock rise
  a_r9_data_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(clk_gen) |-> $stable(dat_q));

endmodule

// File: tb/jitter_smoother_tb_top.sv
module jitter_smoother_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic deep_sel = 1'b0, bypass = 1'b0, path_sel_in = 1'b0, trip_clr = 1'b0;
  logic line_clk_in = 1'b0, line_dat_in = 1'b0;
  logic smooth_clk_out, smooth_dat_out, trip_flag, path_sel_out;

  always #5 clk = ~clk;

  jitter_smoother dut_i (
    .clk(clk), .rst_n(rst_n), .deep_sel(deep_sel), .bypass(bypass),
    .path_sel_in(path_sel_in), .trip_clr(trip_clr), .line_clk_in(line_clk_in),
    .line_dat_in(line_dat_in), .smooth_clk_out(smooth_clk_out),
    .smooth_dat_out(smooth_dat_out), .trip_flag(trip_flag), .path_sel_out(path_sel_out)
  );

  int n_tests = 0, n_fail = 0;

  // Vector table: depth, input period, bit count, trip, min period, max period, data check
  localparam int NROW = 6;
  localparam int ROW_DEEP [NROW] = '{0, 1, 0, 0, 1, 1};
  localparam int ROW_PER  [NROW] = '{8, 8, 6, 10, 6, 10};
  localparam int ROW_N    [NROW] = '{80, 200, 120, 150, 320, 320};
  localparam int ROW_TRIP [NROW] = '{0, 0, 1, 1, 1, 1};
  localparam int ROW_MIN  [NROW] = '{8, 8, 7, 0, 7, 0};
  localparam int ROW_MAX  [NROW] = '{8, 8, 0, 9, 0, 9};
  localparam int ROW_DATA [NROW] = '{1, 1, 0, 0, 0, 0};

  // Output monitor, sampling at the falling edge
  logic mon_clr = 1'b1;
  logic prev_clk, prev_dat, have_prev;
  int   ivl, min_ivl, max_ivl, out_n, bad_chg;
  logic out_bits [0:2047];
  logic sent_bits [0:2047];
  int   n_sent;

  always @(negedge clk) begin
    if (mon_clr) begin
      have_prev <= 1'b0; ivl <= 0; min_ivl <= 999; max_ivl <= 0;
      out_n <= 0; bad_chg <= 0;
      prev_clk <= smooth_clk_out; prev_dat <= smooth_dat_out;
    end else begin
      prev_clk <= smooth_clk_out;
      prev_dat <= smooth_dat_out;
      if (smooth_clk_out && !prev_clk) begin
        if (have_prev) begin
          if (ivl + 1 < min_ivl) min_ivl <= ivl + 1;
          if (ivl + 1 > max_ivl) max_ivl <= ivl + 1;
        end
        have_prev <= 1'b1;
        ivl <= 0;
        if (out_n < 2048) out_bits[out_n] <= smooth_dat_out;
        out_n <= out_n + 1;
      end else begin
        ivl <= ivl + 1;
        if (!bypass && smooth_dat_out != prev_dat) bad_chg <= bad_chg + 1;
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic pat(input int j, input int seed);
    return ((j * 7 + seed + (j >> 2)) % 3) == 0;
  endfunction

  task automatic do_reset();
    @(posedge clk); #1;
    rst_n = 1'b0; mon_clr = 1'b1;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(posedge clk); #1 mon_clr = 1'b0;
  endtask

  task automatic send_bits(input int per, input int n, input int seed);
    for (int j = 0; j < n; j++) begin
      @(posedge clk); #1;
      line_clk_in = 1'b0;
      line_dat_in = pat(j, seed);
      if (n_sent < 2048) sent_bits[n_sent] = pat(j, seed);
      n_sent++;
      repeat (per / 2 - 1) @(posedge clk);
      #1 line_clk_in = 1'b1;
      repeat (per - per / 2) @(posedge clk);
    end
    #1 line_clk_in = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    // R8: reset state
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #2;
    check("R8 reset clk", smooth_clk_out, 0);
    check("R8 reset dat", smooth_dat_out, 0);
    check("R8 reset trip", trip_flag, 0);

    // Table walk
    for (int r = 0; r < NROW; r++) begin
      deep_sel = ROW_DEEP[r][0];
      n_sent = 0;
      do_reset();
      send_bits(ROW_PER[r], ROW_N[r], r);
      repeat (20) @(posedge clk);
      #3;
      check($sformatf("R5 row%0d trip", r), trip_flag, ROW_TRIP[r]);
      if (ROW_MIN[r] != 0)
        check($sformatf("R2 R3 row%0d min period", r), min_ivl, ROW_MIN[r]);
      if (ROW_MAX[r] != 0)
        check($sformatf("R2 R4 row%0d max period", r), max_ivl, ROW_MAX[r]);
      check($sformatf("R9 row%0d data off edge", r), bad_chg, 0);
      if (ROW_DATA[r] != 0) begin
        automatic int half = ROW_DEEP[r] != 0 ? 64 : 16;
        automatic int lim = (out_n < half + n_sent) ? out_n : half + n_sent;
        automatic int bad = 0;
        for (int k = 0; k < lim; k++) begin
          automatic logic e = (k < half) ? 1'b0 : sent_bits[k - half];
          if (out_bits[k] !== e) bad++;
        end
        check($sformatf("R1 R10 row%0d stream errors", r), bad, 0);
        check($sformatf("R1 row%0d enough bits", r), int'(lim > half + 40), 1);
      end
    end

    // R5 R8: trip survives a depth change, divider restarts at 8, clear works
    deep_sel = 1'b0;
    n_sent = 0;
    do_reset();
    send_bits(6, 120, 3);
    #2 check("R5 trip raised", trip_flag, 1);
    @(posedge clk); #1 deep_sel = 1'b1; mon_clr = 1'b1;
    @(posedge clk); #1 mon_clr = 1'b0;
    send_bits(8, 80, 5);
    #2;
    check("R5 R8 trip kept over depth change", trip_flag, 1);
    check("R8 restart min period", min_ivl, 8);
    check("R8 restart max period", max_ivl, 8);
    @(posedge clk); #1 trip_clr = 1'b1;
    @(posedge clk); #1 trip_clr = 1'b0;
    send_bits(8, 40, 6);
    #2 check("R5 trip cleared", trip_flag, 0);

    // R8: reset clears the flag
    deep_sel = 1'b0;
    send_bits(6, 120, 2);
    #1 rst_n = 1'b0;
    #2 check("R8 reset drops trip", trip_flag, 0);
    do_reset();

    // R6: bypass
    bypass = 1'b1;
    line_clk_in = 1'b1; line_dat_in = 1'b0;
    #1;
    check("R6 bypass clk hi", smooth_clk_out, 1);
    check("R6 bypass dat lo", smooth_dat_out, 0);
    line_clk_in = 1'b0; line_dat_in = 1'b1;
    #1;
    check("R6 bypass clk lo", smooth_clk_out, 0);
    check("R6 bypass dat hi", smooth_dat_out, 1);
    bypass = 1'b0; line_dat_in = 1'b0;

    // R7: path select passthrough
    path_sel_in = 1'b1; #1 check("R7 path 1", path_sel_out, 1);
    path_sel_in = 1'b0; #1 check("R7 path 0", path_sel_out, 0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule